// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block keeps two 16-bit data pointers for an 8-bit microcontroller core and gives the core one "current" pointer at a time. A single select flag, DPS, decides which pointer is current. Software reaches the pointers and the flag through a byte-wide special-function-register (SFR) port. The core reads the current pointer on `cur_ptr`, and can step it by one with `ptr_inc`.

A build-time parameter chooses between two variants. In the split variant (`HIDDEN_SWAP = 0`) both pointers have their own SFR byte pair. DPS only picks which pair feeds `cur_ptr`. In the swap variant (`HIDDEN_SWAP = 1`) only the first byte pair is mapped. When DPS changes value, the pointer shown in that pair is parked for the old selection and the parked pointer of the new selection is brought in. Software therefore sees two pointers through one address pair. DPS can be written through a pointer-select register or through an alias bit in the EEPROM control register. The EEPROM control register also shows two read-only status bits.

Top module: `dual_dptr`

## Requirements
- R1: After a synchronous active-low reset, both pointers are 0x0000, DPS is 0, and `cur_ptr` reads 0x0000.
- R2: The pointer-select register at SFR 0xA2 holds DPS in bit 0. Writes set DPS from bit 0. Bits 7..1 always read 0.
- R3: The EEPROM control register at SFR 0x96 shows DPS in bit 2, and writing it sets DPS from bit 2. Bits 1..0 read `ee_stat[1:0]`, and writes to those bits are ignored. Bits 7..3 read 0.
- R4: Split variant: pointer 0 is at 0x82 (low byte) and 0x83 (high byte), and pointer 1 is at 0x84 and 0x85. All four bytes are readable and writable. `cur_ptr` is pointer 1 when DPS is 1 and pointer 0 otherwise.
- R5: Swap variant: only 0x82/0x83 are mapped. 0x84 and 0x85 read 0, and writes to them change no pointer.
- R6: Swap variant: a write that changes DPS parks the pointer shown at 0x82/0x83 for the old selection. From the next cycle, 0x82/0x83 and `cur_ptr` show the pointer parked for the new selection.
- R7: Swap variant: a write that gives DPS its present value performs no swap.
- R8: A cycle with `ptr_inc` high adds 1 to the current pointer. The step wraps from 0xFFFF to 0x0000, and the other pointer is left unchanged.
- R9: `ptr_inc` is ignored in any cycle in which `sfr_we` is high. A pointer byte write in that cycle takes effect without the step.
- R10: A read of any SFR address other than those named above returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | SFR address for reads and writes |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | SFR write strobe, one write per cycle |
| sfr_rdata | output | 8 | Combinational read data for `sfr_addr` |
| ptr_inc | input | 1 | Step the current pointer by one |
| ee_stat | input | 2 | Status shown in bits 1..0 of the EEPROM control register |
| cur_ptr | output | 16 | Current data pointer |

## Verification
The bench builds two copies of the block side by side: one with `HIDDEN_SWAP = 0` and one with `HIDDEN_SWAP = 1`. Both copies receive the same SFR writes and step pulses. The same write sequence therefore shows the separate byte pairs in one copy and the park-and-restore exchange in the other. The sequences cover a swap followed by a same-value DPS write, DPS writes through both registers, a step wrapping from 0xFFFF, and a step colliding with a write.

// File: rtl/dptr_pkg.sv
// Package: shared widths, SFR map and the DPS write decode for the
// dual data pointer unit. Assumes an 8-bit SFR bus and 16-bit pointers.
package dptr_pkg;

    localparam int BYTE_W      = 8;
    localparam int PTR_W       = 2 * BYTE_W;
    localparam int STAT_W      = 2;
    localparam int SEL_DPS_BIT = 0;
    localparam int EEC_DPS_BIT = 2;

    typedef logic [BYTE_W-1:0] sfr_byte_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    localparam sfr_byte_t A_DP0_LO = 8'h82;
    localparam sfr_byte_t A_DP0_HI = 8'h83;
    localparam sfr_byte_t A_DP1_LO = 8'h84;
    localparam sfr_byte_t A_DP1_HI = 8'h85;
    localparam sfr_byte_t A_SEL    = 8'hA2;
    localparam sfr_byte_t A_EEC    = 8'h96;

    typedef struct packed {
        logic req;
        logic val;
    } dps_req_t;

    // Decode an SFR write into a request to load DPS and the value to load.
    function automatic dps_req_t decode_dps(input sfr_byte_t addr,
                                            input sfr_byte_t wdata,
                                            input logic      we);
        dps_req_t r;
        r.req = we && ((addr == A_SEL) || (addr == A_EEC));
        r.val = (addr == A_EEC) ? wdata[EEC_DPS_BIT] : wdata[SEL_DPS_BIT];
        return r;
    endfunction

    // Pointer step with natural wrap at the pointer width.
    function automatic ptr_t step(input ptr_t p);
        return p + ptr_t'(1);
    endfunction

endpackage

// File: rtl/dptr_dps_ctl.sv
// DPS flag register with its two write paths: the pointer-select register
// and the alias bit in the EEPROM control register. It also provides read
// data for both registers. Assumes at most one SFR write per cycle.
module dptr_dps_ctl
    import dptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  sfr_byte_t         sfr_addr,
    input  sfr_byte_t         sfr_wdata,
    input  logic              sfr_we,
    input  logic [STAT_W-1:0] ee_stat,
    output logic              dps_q,
    output sfr_byte_t         rdata
);

    dps_req_t req;
    assign req = decode_dps(sfr_addr, sfr_wdata, sfr_we);

    // Hold DPS; load it from whichever register was written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dps_q <= 1'b0;
        else if (req.req)
            dps_q <= req.val;
    end

    // Read data for the two registers; status bits come straight from input.
    always_comb begin
        rdata = '0;
        case (sfr_addr)
            A_SEL: rdata[SEL_DPS_BIT] = dps_q;
            A_EEC: begin
                rdata[EEC_DPS_BIT]  = dps_q;
                rdata[STAT_W-1:0]   = ee_stat;
            end
            default: rdata = '0;
        endcase
    end

    // R1: reset clears DPS.
    a_r1_dps_reset: assert property (@(posedge clk) !rst_n |=> !dps_q);

    // R2: DPS changes only through a write to one of its registers.
    a_r2_dps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req.req |=> $stable(dps_q));

    // R3: an alias write lands bit 2 in DPS.
    a_r3_alias_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_we && sfr_addr == A_EEC) |=> (dps_q == $past(sfr_wdata[EEC_DPS_BIT])));

endmodule

// File: rtl/dptr_bank_split.sv
// Split-variant pointer storage: two pointers, each with its own SFR byte
// pair. DPS only selects which one is current and which one steps.
// Assumes DPS is registered elsewhere and changes only on SFR writes.
module dptr_bank_split
    import dptr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sfr_byte_t sfr_addr,
    input  sfr_byte_t sfr_wdata,
    input  logic      sfr_we,
    input  logic      ptr_inc,
    input  logic      dps_q,
    output sfr_byte_t rdata,
    output ptr_t      cur_ptr
);

    localparam int N_PTR = 2;

    ptr_t slot [N_PTR];

    for (genvar g = 0; g < N_PTR; g++) begin : g_slot
        localparam sfr_byte_t LO  = (g == 0) ? A_DP0_LO : A_DP1_LO;
        localparam sfr_byte_t HI  = (g == 0) ? A_DP0_HI : A_DP1_HI;
        localparam bit        SEL = (g != 0);

        ptr_t q;

        // Byte writes take priority; otherwise step when this slot is current.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (sfr_we) begin
                if (sfr_addr == LO)
                    q[BYTE_W-1:0] <= sfr_wdata;
                else if (sfr_addr == HI)
                    q[PTR_W-1:BYTE_W] <= sfr_wdata;
            end else if (ptr_inc && (dps_q == SEL))
                q <= step(q);
        end

        assign slot[g] = q;
    end

    assign cur_ptr = slot[dps_q];

    // Byte read-back for both pairs.
    always_comb begin
        case (sfr_addr)
            A_DP0_LO: rdata = slot[0][BYTE_W-1:0];
            A_DP0_HI: rdata = slot[0][PTR_W-1:BYTE_W];
            A_DP1_LO: rdata = slot[1][BYTE_W-1:0];
            A_DP1_HI: rdata = slot[1][PTR_W-1:BYTE_W];
            default:  rdata = '0;
        endcase
    end

    // R8: a step without a write advances the current pointer by one.
    a_r8_step_split: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && !sfr_we) |=> (cur_ptr == step($past(cur_ptr))));

    // R8: the other pointer is not touched by a step.
    a_r8_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && !sfr_we) |=> (slot[!dps_q] == $past(slot[!dps_q])));

    // R9: a write to a non-pointer address blocks a step in the same cycle.
    a_r9_write_blocks_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_we && ptr_inc && sfr_addr != A_DP0_LO && sfr_addr != A_DP0_HI &&
         sfr_addr != A_DP1_LO && sfr_addr != A_DP1_HI &&
         sfr_addr != A_SEL && sfr_addr != A_EEC) |=> $stable(cur_ptr));

endmodule

// File: rtl/dptr_bank_hidden.sv
// Swap-variant pointer storage: one visible pointer at the first SFR pair
// and one parked pointer. A DPS change exchanges the two in one cycle.
// Assumes DPS is registered elsewhere with the same write decode.
module dptr_bank_hidden
    import dptr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sfr_byte_t sfr_addr,
    input  sfr_byte_t sfr_wdata,
    input  logic      sfr_we,
    input  logic      ptr_inc,
    input  logic      dps_q,
    output sfr_byte_t rdata,
    output ptr_t      cur_ptr
);

    ptr_t     vis_q;
    ptr_t     park_q;
    dps_req_t req;
    logic     swap;

    assign req  = decode_dps(sfr_addr, sfr_wdata, sfr_we);
    assign swap = req.req && (req.val != dps_q);

    // Visible pointer: swap-in, byte write or step, in that priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vis_q <= '0;
        else if (swap)
            vis_q <= park_q;
        else if (sfr_we) begin
            if (sfr_addr == A_DP0_LO)
                vis_q[BYTE_W-1:0] <= sfr_wdata;
            else if (sfr_addr == A_DP0_HI)
                vis_q[PTR_W-1:BYTE_W] <= sfr_wdata;
        end else if (ptr_inc)
            vis_q <= step(vis_q);
    end

    // Parked pointer: receives the visible one on a swap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            park_q <= '0;
        else if (swap)
            park_q <= vis_q;
    end

    assign cur_ptr = vis_q;

    // Only the first pair is mapped in this variant.
    always_comb begin
        case (sfr_addr)
            A_DP0_LO: rdata = vis_q[BYTE_W-1:0];
            A_DP0_HI: rdata = vis_q[PTR_W-1:BYTE_W];
            default:  rdata = '0;
        endcase
    end

    // R5: writes to the second pair's addresses change no pointer.
    a_r5_unmapped_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_we && (sfr_addr == A_DP1_LO || sfr_addr == A_DP1_HI))
        |=> ($stable(vis_q) && $stable(park_q)));

    // R6: a DPS change exchanges visible and parked pointers.
    a_r6_swap_exchange: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> ((vis_q == $past(park_q)) && (park_q == $past(vis_q))));

    // R7: rewriting the present DPS value leaves both pointers alone.
    a_r7_same_dps_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (req.req && req.val == dps_q) |=> ($stable(vis_q) && $stable(park_q)));

    // R8: a step without a write advances the visible pointer by one.
    a_r8_step_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && !sfr_we) |=> (vis_q == step($past(vis_q))));

endmodule

// File: rtl/dual_dptr.sv
// Dual data pointer unit top: DPS control plus one of two storage variants
// chosen by HIDDEN_SWAP. Read data is the OR of the sub-blocks, each of
// which drives zero for addresses it does not own.
module dual_dptr
    import dptr_pkg::*;
#(
    parameter bit HIDDEN_SWAP = 1'b0
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BYTE_W-1:0]     sfr_addr,
    input  logic [BYTE_W-1:0]     sfr_wdata,
    input  logic                  sfr_we,
    output logic [BYTE_W-1:0]     sfr_rdata,
    input  logic                  ptr_inc,
    input  logic [STAT_W-1:0]     ee_stat,
    output logic [PTR_W-1:0]      cur_ptr
);

    logic      dps_q;
    sfr_byte_t ctl_rd;
    sfr_byte_t bank_rd;

    dptr_dps_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_addr  (sfr_addr),
        .sfr_wdata (sfr_wdata),
        .sfr_we    (sfr_we),
        .ee_stat   (ee_stat),
        .dps_q     (dps_q),
        .rdata     (ctl_rd)
    );

    if (HIDDEN_SWAP) begin : g_hidden
        dptr_bank_hidden u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .sfr_addr  (sfr_addr),
            .sfr_wdata (sfr_wdata),
            .sfr_we    (sfr_we),
            .ptr_inc   (ptr_inc),
            .dps_q     (dps_q),
            .rdata     (bank_rd),
            .cur_ptr   (cur_ptr)
        );
    end else begin : g_split
        dptr_bank_split u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .sfr_addr  (sfr_addr),
            .sfr_wdata (sfr_wdata),
            .sfr_we    (sfr_we),
            .ptr_inc   (ptr_inc),
            .dps_q     (dps_q),
            .rdata     (bank_rd),
            .cur_ptr   (cur_ptr)
        );
    end

    // Merge read data; sub-blocks return zero outside their addresses.
    assign sfr_rdata = ctl_rd | bank_rd;

    // R1: reset leaves the current pointer at zero.
    a_r1_ptr_reset: assert property (@(posedge clk) !rst_n |=> (cur_ptr == '0));

    // R10: an address owned by nobody reads zero.
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == 8'h00) |-> (sfr_rdata == '0));

endmodule

// File: tb/dual_dptr_test.sv
// Directed bench: both variants side by side under shared stimulus.
module dual_dptr_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  addr;
    logic [7:0]  wdata;
    logic        we;
    logic        inc;
    logic [1:0]  stat;
    logic [7:0]  rd_s, rd_h;
    logic [15:0] cur_s, cur_h;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dual_dptr #(.HIDDEN_SWAP(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(addr), .sfr_wdata(wdata),
        .sfr_we(we), .sfr_rdata(rd_s), .ptr_inc(inc), .ee_stat(stat),
        .cur_ptr(cur_s));

    dual_dptr #(.HIDDEN_SWAP(1'b1)) uut_hid (
        .clk(clk), .rst_n(rst_n), .sfr_addr(addr), .sfr_wdata(wdata),
        .sfr_we(we), .sfr_rdata(rd_h), .ptr_inc(inc), .ee_stat(stat),
        .cur_ptr(cur_h));

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; we = 1'b0; inc = 1'b0; addr = 8'h00; wdata = 8'h00;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; addr = 8'h00;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] vs, output logic [7:0] vh);
        addr = a;
        #1;
        vs = rd_s;
        vh = rd_h;
        addr = 8'h00;
    endtask

    task automatic pulse_inc();
        @(negedge clk);
        inc = 1'b1;
        @(negedge clk);
        inc = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] vs, vh;
        do_reset();
        chk("R1 split cur", cur_s, 16'h0000);
        chk("R1 swap cur", cur_h, 16'h0000);
        peek(8'hA2, vs, vh);
        chk("R1 dps clear", {8'h00, vs}, 16'h0000);
        peek(8'h82, vs, vh);
        chk("R1 dp0 low clear", {vh, vs}, 16'h0000);
    endtask

    task automatic t_select();
        logic [7:0] vs, vh;
        do_reset();
        wr(8'hA2, 8'hFF);
        peek(8'hA2, vs, vh);
        chk("R2 select reads 01", {8'h00, vs}, 16'h0001);
        wr(8'hA2, 8'hFE);
        peek(8'hA2, vs, vh);
        chk("R2 select reads 00", {8'h00, vs}, 16'h0000);
    endtask

    task automatic t_eeprom();
        logic [7:0] vs, vh;
        do_reset();
        stat = 2'b10;
        wr(8'h96, 8'hFF);
        peek(8'h96, vs, vh);
        chk("R3 eecon reads 06", {8'h00, vs}, 16'h0006);
        peek(8'hA2, vs, vh);
        chk("R3 alias sets dps", {8'h00, vs}, 16'h0001);
        wr(8'h96, 8'h03);
        peek(8'h96, vs, vh);
        chk("R3 status write ignored", {8'h00, vs}, 16'h0002);
        peek(8'hA2, vs, vh);
        chk("R3 alias clears dps", {8'h00, vs}, 16'h0000);
        stat = 2'b01;
        peek(8'h96, vs, vh);
        chk("R3 status follows input", {8'h00, vs}, 16'h0001);
    endtask

    task automatic t_split();
        logic [7:0] vs, vh;
        do_reset();
        wr(8'h82, 8'h34); wr(8'h83, 8'h12);
        wr(8'h84, 8'hCD); wr(8'h85, 8'hAB);
        chk("R4 dps0 selects dp0", cur_s, 16'h1234);
        peek(8'h84, vs, vh);
        chk("R4 dp1 low read", {8'h00, vs}, 16'h00CD);
        peek(8'h85, vs, vh);
        chk("R4 dp1 high read", {8'h00, vs}, 16'h00AB);
        wr(8'hA2, 8'h01);
        chk("R4 dps1 selects dp1", cur_s, 16'hABCD);
        peek(8'h82, vs, vh);
        chk("R4 dp0 kept", {8'h00, vs}, 16'h0034);
    endtask

    task automatic t_hidden_map();
        logic [7:0] vs, vh;
        do_reset();
        wr(8'h82, 8'h78); wr(8'h83, 8'h56);
        wr(8'h84, 8'h11);
        peek(8'h84, vs, vh);
        chk("R5 swap 0x84 reads 0", {8'h00, vh}, 16'h0000);
        chk("R5 swap cur unchanged", cur_h, 16'h5678);
        wr(8'hA2, 8'h01);
        chk("R5 parked slot untouched", cur_h, 16'h0000);
    endtask

    task automatic t_swap();
        logic [7:0] vs, vh;
        do_reset();
        wr(8'h82, 8'h34); wr(8'h83, 8'h12);
        wr(8'hA2, 8'h01);
        chk("R6 swap-in empty slot", cur_h, 16'h0000);
        peek(8'h82, vs, vh);
        chk("R6 mapped low after swap", {8'h00, vh}, 16'h0000);
        wr(8'h82, 8'hCD); wr(8'h83, 8'hAB);
        wr(8'hA2, 8'h00);
        chk("R6 restore slot0", cur_h, 16'h1234);
        peek(8'h83, vs, vh);
        chk("R6 mapped high restored", {8'h00, vh}, 16'h0012);
        wr(8'h96, 8'h04);
        chk("R6 swap via alias", cur_h, 16'hABCD);
    endtask

    task automatic t_same();
        wr(8'h96, 8'h04);
        chk("R7 same value via alias", cur_h, 16'hABCD);
        wr(8'hA2, 8'h01);
        chk("R7 same value via select", cur_h, 16'hABCD);
        wr(8'hA2, 8'h00);
        chk("R7 parked intact", cur_h, 16'h1234);
    endtask

    task automatic t_inc();
        logic [7:0] vs, vh;
        do_reset();
        wr(8'h84, 8'hFF); wr(8'h85, 8'hFF);
        wr(8'h82, 8'h05);
        wr(8'hA2, 8'h01);
        pulse_inc();
        chk("R8 split wrap", cur_s, 16'h0000);
        peek(8'h82, vs, vh);
        chk("R8 split other kept", {8'h00, vs}, 16'h0005);
        chk("R8 swap step", cur_h, 16'h0001);
        wr(8'hA2, 8'h00);
        pulse_inc();
        chk("R8 split step dp0", cur_s, 16'h0006);
        chk("R8 swap step slot0", cur_h, 16'h0006);
        wr(8'h82, 8'hFF); wr(8'h83, 8'hFF);
        pulse_inc();
        chk("R8 split wrap dp0", cur_s, 16'h0000);
        chk("R8 swap wrap", cur_h, 16'h0000);
    endtask

    task automatic t_collide();
        do_reset();
        wr(8'h82, 8'hFF);
        @(negedge clk);
        addr = 8'h82; wdata = 8'h10; we = 1'b1; inc = 1'b1;
        @(negedge clk);
        we = 1'b0; inc = 1'b0; addr = 8'h00;
        chk("R9 split write wins", cur_s, 16'h0010);
        chk("R9 swap write wins", cur_h, 16'h0010);
        @(negedge clk);
        addr = 8'h00; wdata = 8'h55; we = 1'b1; inc = 1'b1;
        @(negedge clk);
        we = 1'b0; inc = 1'b0;
        chk("R9 split step dropped", cur_s, 16'h0010);
        chk("R9 swap step dropped", cur_h, 16'h0010);
        pulse_inc();
        chk("R9 split step resumes", cur_s, 16'h0011);
    endtask

    task automatic t_unmapped();
        logic [7:0] vs, vh;
        peek(8'h90, vs, vh);
        chk("R10 0x90 reads 0", {vh, vs}, 16'h0000);
        peek(8'h86, vs, vh);
        chk("R10 0x86 reads 0", {vh, vs}, 16'h0000);
    endtask

    initial begin
        rst_n = 1'b0; we = 1'b0; inc = 1'b0;
        addr = 8'h00; wdata = 8'h00; stat = 2'b00;
        t_reset();
        t_select();
        t_eeprom();
        t_split();
        t_hidden_map();
        t_swap();
        t_same();
        t_inc();
        t_collide();
        t_unmapped();
        finish_up();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule